// File: doc/BRIEF.md
# Sequenced Retransmit Store for a Link Transmitter

This block sits between a byte-wide packet source and a link transmitter. Each incoming packet is first written in full into a local store. It is then sent out as a frame: a two-byte header carrying a 12-bit sequence number, the payload bytes, and a four-byte CRC-32 trailer. A transmitted packet stays in the store until the far end acknowledges it.

The far end returns acknowledgements that carry a sequence number. A positive acknowledgement frees every stored packet up to and including that number. A negative acknowledgement frees the same set. It then sends again, oldest first, every remaining packet that has already been transmitted. Each resent frame has the original sequence number and is bit-identical to the first copy. While a retransmission is pending or running, or while the store is full, the source is held off by a low ready.

The store holds payload bytes only. The header and trailer are rebuilt on every send, so a retransmitted frame passes through the same framing path as a new one.

Top module: `lnk_replay_tx`

## Requirements
- R1: Each frame is laid out as follows. First byte: {4'b0000, seq[11:8]}, with out_sop high. Second byte: seq[7:0]. Then the payload bytes in the order they were accepted. Then four CRC bytes, most significant byte first, with out_eop high on the last one. A frame is started only after the packet's end marker has been accepted.
- R2: The trailer is computed as follows.
  - Polynomial 0x04C11DB7, register initialised to all ones.
  - Each byte is shifted in most significant bit first, with no bit reflection.
  - The CRC covers the two header bytes followed by the payload.
  - The final register value is inverted before it is sent.
- R3: The first packet accepted after reset gets sequence 0. Each later accepted packet gets the next number, modulo 4096 (4095 is followed by 0).
- R4: While out_valid is high and out_ready is low, out_valid, out_data and the markers hold their values.
- R5: A positive acknowledgement with sequence N frees every fully transmitted stored packet whose sequence is at or before N, using modulo-4096 distance from the oldest stored packet. An acknowledgement that names a packet not yet fully transmitted, or one already freed, changes nothing.
- R6: A negative acknowledgement with sequence N first frees as in R5. After any frame in flight has finished, it resends every transmitted, unfreed packet from N+1 up to the newest, in the original order, with unchanged bytes.
- R7: in_ready is low from the cycle after a negative acknowledgement that causes a resend until the last resent frame has finished.
- R8: in_ready is low while the payload store holds 2^DATA_AW bytes, or while 2^DESC_AW packets are stored. Freeing packets by acknowledgement lets input resume.
- R9: During and right after reset, out_valid is low and in_ready is high.
- R10: A negative acknowledgement with no transmitted packets after N causes no resend and does not lower in_ready.
- R11: A start marker that arrives before the previous packet's end marker discards the unfinished bytes. The new packet starts fresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take an input byte |
| in_data | input | 8 | Input payload byte |
| in_sop | input | 1 | First byte of a packet |
| in_eop | input | 1 | Last byte of a packet |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Transmitter takes the output byte |
| out_data | output | 8 | Framed output byte |
| out_sop | output | 1 | First header byte of a frame |
| out_eop | output | 1 | Last CRC byte of a frame |
| ack_valid | input | 1 | Acknowledgement strobe |
| ack_nak | input | 1 | 1 = negative acknowledgement, 0 = positive |
| ack_seq | input | SEQ_W | Sequence number carried by the acknowledgement |

## Verification
Internal state faults show up at the ports in characteristic ways:
- A wrong oldest-packet pointer or sequence counter shows up within one frame, as a wrong header byte, a wrong trailer, or a resend that starts at the wrong packet.
- An off-by-one in release counting shows up only at the next negative acknowledgement, as one frame too many or too few.
- A wrong free-space count shows up as in_ready falling early or never, on the very byte that reaches the store limit.
- Sequence wrap errors appear only after 4096 packets. The sweep therefore runs past the wrap and then forces a resend across it.

// File: rtl/lrb_pkg.sv
package lrb_pkg;
   localparam logic [31:0] CRC_POLY = 32'h04C11DB7;

   typedef enum logic [2:0] {
      FR_IDLE,
      FR_HDR_HI,
      FR_HDR_LO,
      FR_BODY,
      FR_CHECK
   } frame_state_e;

   function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
      logic [31:0] r;
      r = c;
      for (int i = 7; i >= 0; i--) begin
         if (r[31] ^ d[i]) r = {r[30:0], 1'b0} ^ CRC_POLY;
         else              r = {r[30:0], 1'b0};
      end
      return r;
   endfunction
endpackage

// File: rtl/lrb_crc32.sv
module lrb_crc32 #(
   parameter logic [31:0] INIT = 32'hFFFF_FFFF
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clear,
   input  logic        en,
   input  logic [7:0]  din,
   output logic [31:0] crc_q
);
   import lrb_pkg::*;

   always_ff @(posedge clk) begin
      if (!rst_n)     crc_q <= INIT;
      else if (clear) crc_q <= INIT;
      else if (en)    crc_q <= crc32_step(crc_q, din);
   end
endmodule

// File: rtl/lrb_store.sv
module lrb_store #(
   parameter int DATA_AW = 12,
   parameter int DESC_AW = 4,
   parameter int LEN_W   = 13
) (
   input  logic               clk,
   input  logic               wr_en,
   input  logic [DATA_AW-1:0] wr_addr,
   input  logic [7:0]         wr_data,
   input  logic [DATA_AW-1:0] rd_addr,
   output logic [7:0]         rd_data,
   input  logic               dwr_en,
   input  logic [DESC_AW-1:0] dwr_idx,
   input  logic [DATA_AW:0]   dwr_start,
   input  logic [LEN_W-1:0]   dwr_len,
   input  logic [DESC_AW-1:0] old_idx,
   output logic [DATA_AW:0]   old_start,
   input  logic [DESC_AW-1:0] nxt_idx,
   output logic [DATA_AW-1:0] nxt_start,
   output logic [LEN_W-1:0]   nxt_len
);
   localparam int DEPTH  = 1 << DATA_AW;
   localparam int DDEPTH = 1 << DESC_AW;

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end
   assign rd_data = mem[rd_addr];

   logic [DATA_AW:0] start_w [DDEPTH];
   logic [LEN_W-1:0] len_w   [DDEPTH];

   for (genvar g = 0; g < DDEPTH; g++) begin : g_desc
      logic [DATA_AW:0] st_q;
      logic [LEN_W-1:0] ln_q;
      always_ff @(posedge clk) begin
         if (dwr_en && dwr_idx == DESC_AW'(g)) begin
            st_q <= dwr_start;
            ln_q <= dwr_len;
         end
      end
      assign start_w[g] = st_q;
      assign len_w[g]   = ln_q;
   end

   logic [DATA_AW:0] nxt_full;
   assign old_start = start_w[old_idx];
   assign nxt_full  = start_w[nxt_idx];
   assign nxt_start = nxt_full[DATA_AW-1:0];
   assign nxt_len   = len_w[nxt_idx];
endmodule

// File: rtl/lrb_framer.sv
module lrb_framer #(
   parameter int DATA_AW = 12,
   parameter int LEN_W   = 13,
   parameter int SEQ_W   = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [DATA_AW-1:0] start_addr,
   input  logic [LEN_W-1:0]   start_len,
   input  logic [SEQ_W-1:0]   start_seq,
   output logic               busy,
   output logic               done,
   output logic [DATA_AW-1:0] rd_addr,
   input  logic [7:0]         rd_data,
   output logic               out_valid,
   input  logic               out_ready,
   output logic [7:0]         out_data,
   output logic               out_sop,
   output logic               out_eop
);
   import lrb_pkg::*;

   frame_state_e       st_q;
   logic [SEQ_W-1:0]   seq_q;
   logic [DATA_AW-1:0] addr_q;
   logic [LEN_W-1:0]   remain_q;
   logic [1:0]         idx_q;
   logic [15:0]        hdr;
   logic [31:0]        crc_q;
   logic [31:0]        crc_fin;
   logic               fire;
   logic               crc_en;

   assign hdr       = 16'(seq_q);
   assign crc_fin   = ~crc_q;
   assign busy      = (st_q != FR_IDLE);
   assign out_valid = busy;
   assign fire      = out_valid && out_ready;
   assign rd_addr   = addr_q;
   assign out_sop   = (st_q == FR_HDR_HI);
   assign out_eop   = (st_q == FR_CHECK) && (idx_q == 2'd3);
   assign done      = fire && out_eop;
   assign crc_en    = fire && (st_q == FR_HDR_HI || st_q == FR_HDR_LO || st_q == FR_BODY);

   always_comb begin
      out_data = 8'h00;
      unique case (st_q)
         FR_HDR_HI: out_data = hdr[15:8];
         FR_HDR_LO: out_data = hdr[7:0];
         FR_BODY:   out_data = rd_data;
         FR_CHECK: begin
            unique case (idx_q)
               2'd0: out_data = crc_fin[31:24];
               2'd1: out_data = crc_fin[23:16];
               2'd2: out_data = crc_fin[15:8];
               default: out_data = crc_fin[7:0];
            endcase
         end
         default: out_data = 8'h00;
      endcase
   end

   lrb_crc32 u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (start),
      .en    (crc_en),
      .din   (out_data),
      .crc_q (crc_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= FR_IDLE;
         seq_q    <= '0;
         addr_q   <= '0;
         remain_q <= '0;
         idx_q    <= '0;
      end else begin
         unique case (st_q)
            FR_IDLE: if (start) begin
               st_q     <= FR_HDR_HI;
               seq_q    <= start_seq;
               addr_q   <= start_addr;
               remain_q <= start_len;
            end
            FR_HDR_HI: if (fire) st_q <= FR_HDR_LO;
            FR_HDR_LO: if (fire) st_q <= FR_BODY;
            FR_BODY: if (fire) begin
               addr_q   <= addr_q + 1'b1;
               remain_q <= remain_q - 1'b1;
               if (remain_q == LEN_W'(1)) begin
                  st_q  <= FR_CHECK;
                  idx_q <= 2'd0;
               end
            end
            FR_CHECK: if (fire) begin
               idx_q <= idx_q + 1'b1;
               if (idx_q == 2'd3) st_q <= FR_IDLE;
            end
            default: st_q <= FR_IDLE;
         endcase
      end
   end

   a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop)));

   a_r1_marker_excl: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !(out_sop && out_eop));

   a_r1_start_len: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |-> (start_len != '0));
endmodule

// File: rtl/lrb_ctrl.sv
module lrb_ctrl #(
   parameter int DATA_AW = 12,
   parameter int DESC_AW = 4,
   parameter int LEN_W   = 13,
   parameter int SEQ_W   = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic               in_sop,
   input  logic               in_eop,
   output logic               in_ready,
   input  logic               ack_valid,
   input  logic               ack_nak,
   input  logic [SEQ_W-1:0]   ack_seq,
   output logic               mem_we,
   output logic [DATA_AW-1:0] mem_waddr,
   output logic               desc_we,
   output logic [DESC_AW-1:0] desc_widx,
   output logic [DATA_AW:0]   desc_wstart,
   output logic [LEN_W-1:0]   desc_wlen,
   output logic [DESC_AW-1:0] old_idx,
   input  logic [DATA_AW:0]   old_start,
   output logic [DESC_AW-1:0] nxt_idx,
   output logic               fr_start,
   output logic [SEQ_W-1:0]   fr_seq,
   input  logic               fr_busy,
   input  logic               fr_done
);
   localparam int DEPTH  = 1 << DATA_AW;
   localparam int DDEPTH = 1 << DESC_AW;
   localparam int PW     = DESC_AW + 1;

   logic [PW-1:0]      head_q, tail_q, sp_q, head_nx;
   logic [PW-1:0]      count, sent;
   logic [SEQ_W-1:0]   nseq_q, hseq, kdist;
   logic [DATA_AW:0]   wp_q, ps_q, oldest, used, waddr, wnext;
   logic               rew_q, rpl_q;
   logic               ack_ok, nak_rpl, fire_in, commit, do_rewind;

   assign count   = tail_q - head_q;
   assign sent    = sp_q - head_q;
   assign hseq    = nseq_q - SEQ_W'(count);
   assign kdist   = ack_seq - hseq + SEQ_W'(1);
   assign ack_ok  = ack_valid && (kdist <= SEQ_W'(sent));
   assign head_nx = ack_ok ? head_q + PW'(kdist) : head_q;
   assign nak_rpl = ack_ok && ack_nak && (head_nx != sp_q);

   assign oldest   = (count == '0) ? ps_q : old_start;
   assign used     = wp_q - oldest;
   assign in_ready = !rpl_q && !rew_q && (used < (DATA_AW+1)'(DEPTH)) && (count < PW'(DDEPTH));
   assign fire_in  = in_valid && in_ready;
   assign commit   = fire_in && in_eop;
   assign waddr    = in_sop ? ps_q : wp_q;
   assign wnext    = waddr + 1'b1;

   assign mem_we      = fire_in;
   assign mem_waddr   = waddr[DATA_AW-1:0];
   assign desc_we     = commit;
   assign desc_widx   = tail_q[DESC_AW-1:0];
   assign desc_wstart = ps_q;
   assign desc_wlen   = LEN_W'(wnext - ps_q);

   assign old_idx   = head_q[DESC_AW-1:0];
   assign nxt_idx   = sp_q[DESC_AW-1:0];
   assign do_rewind = rew_q && !fr_busy;
   assign fr_start  = !fr_busy && !rew_q && (sp_q != tail_q);
   assign fr_seq    = hseq + SEQ_W'(sent);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
         sp_q   <= '0;
         nseq_q <= '0;
         wp_q   <= '0;
         ps_q   <= '0;
         rew_q  <= 1'b0;
         rpl_q  <= 1'b0;
      end else begin
         head_q <= head_nx;
         if (fire_in) wp_q <= wnext;
         if (commit) begin
            tail_q <= tail_q + 1'b1;
            nseq_q <= nseq_q + 1'b1;
            ps_q   <= wnext;
         end
         if (do_rewind)    sp_q <= head_nx;
         else if (fr_done) sp_q <= sp_q + 1'b1;
         if (nak_rpl)        rew_q <= 1'b1;
         else if (do_rewind) rew_q <= 1'b0;
         if (nak_rpl) rpl_q <= 1'b1;
         else if (rpl_q && !rew_q && !fr_busy && sp_q == tail_q) rpl_q <= 1'b0;
      end
   end

   a_r5_sent_window: assert property (@(posedge clk) disable iff (!rst_n)
      (sp_q - head_q) <= (tail_q - head_q));

   a_r8_store_bound: assert property (@(posedge clk) disable iff (!rst_n)
      used <= (DATA_AW+1)'(DEPTH));

   a_r8_ring_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= PW'(DDEPTH));

   a_r6_rewind_to_head: assert property (@(posedge clk) disable iff (!rst_n)
      (do_rewind && !nak_rpl) |=> (sp_q == head_q));
endmodule

// File: rtl/lnk_replay_tx.sv
module lnk_replay_tx #(
   parameter int DATA_AW = 12,
   parameter int DESC_AW = 4,
   parameter int MAX_PKT = 4096,
   parameter int SEQ_W   = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [7:0]       in_data,
   input  logic             in_sop,
   input  logic             in_eop,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [7:0]       out_data,
   output logic             out_sop,
   output logic             out_eop,
   input  logic             ack_valid,
   input  logic             ack_nak,
   input  logic [SEQ_W-1:0] ack_seq
);
   localparam int LEN_W = $clog2(MAX_PKT + 1);

   if (SEQ_W < 9 || SEQ_W > 16) begin : g_chk_seq
      $error("SEQ_W must lie between 9 and 16");
   end
   if (MAX_PKT < 1 || MAX_PKT > (1 << DATA_AW)) begin : g_chk_pkt
      $error("MAX_PKT must fit in the payload store");
   end
   if (SEQ_W < DESC_AW + 2) begin : g_chk_ring
      $error("descriptor ring too deep for the sequence space");
   end

   logic               mem_we, desc_we, fr_start, fr_busy, fr_done;
   logic [DATA_AW-1:0] mem_waddr, rd_addr, nxt_start;
   logic [7:0]         rd_data;
   logic [DESC_AW-1:0] desc_widx, old_idx, nxt_idx;
   logic [DATA_AW:0]   desc_wstart, old_start;
   logic [LEN_W-1:0]   desc_wlen, nxt_len;
   logic [SEQ_W-1:0]   fr_seq;

   lrb_ctrl #(.DATA_AW(DATA_AW), .DESC_AW(DESC_AW), .LEN_W(LEN_W), .SEQ_W(SEQ_W)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .in_sop      (in_sop),
      .in_eop      (in_eop),
      .in_ready    (in_ready),
      .ack_valid   (ack_valid),
      .ack_nak     (ack_nak),
      .ack_seq     (ack_seq),
      .mem_we      (mem_we),
      .mem_waddr   (mem_waddr),
      .desc_we     (desc_we),
      .desc_widx   (desc_widx),
      .desc_wstart (desc_wstart),
      .desc_wlen   (desc_wlen),
      .old_idx     (old_idx),
      .old_start   (old_start),
      .nxt_idx     (nxt_idx),
      .fr_start    (fr_start),
      .fr_seq      (fr_seq),
      .fr_busy     (fr_busy),
      .fr_done     (fr_done)
   );

   lrb_store #(.DATA_AW(DATA_AW), .DESC_AW(DESC_AW), .LEN_W(LEN_W)) u_store (
      .clk       (clk),
      .wr_en     (mem_we),
      .wr_addr   (mem_waddr),
      .wr_data   (in_data),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data),
      .dwr_en    (desc_we),
      .dwr_idx   (desc_widx),
      .dwr_start (desc_wstart),
      .dwr_len   (desc_wlen),
      .old_idx   (old_idx),
      .old_start (old_start),
      .nxt_idx   (nxt_idx),
      .nxt_start (nxt_start),
      .nxt_len   (nxt_len)
   );

   lrb_framer #(.DATA_AW(DATA_AW), .LEN_W(LEN_W), .SEQ_W(SEQ_W)) u_framer (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (fr_start),
      .start_addr (nxt_start),
      .start_len  (nxt_len),
      .start_seq  (fr_seq),
      .busy       (fr_busy),
      .done       (fr_done),
      .rd_addr    (rd_addr),
      .rd_data    (rd_data),
      .out_valid  (out_valid),
      .out_ready  (out_ready),
      .out_data   (out_data),
      .out_sop    (out_sop),
      .out_eop    (out_eop)
   );
endmodule

// File: tb/tb_lnk_replay_tx.sv
module tb_lnk_replay_tx;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic in_ready, out_valid, out_sop, out_eop;
   logic [7:0] out_data;
   logic out_ready = 1'b0;
   logic ack_valid = 1'b0, ack_nak = 1'b0;
   logic [11:0] ack_seq = '0;

   always #2.5 clk = ~clk;

   lnk_replay_tx #(.DATA_AW(6), .DESC_AW(2), .MAX_PKT(32), .SEQ_W(12)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_sop(out_sop), .out_eop(out_eop),
      .ack_valid(ack_valid), .ack_nak(ack_nak), .ack_seq(ack_seq));

   int checks = 0, fails = 0, cyc = 0;
   int frames_seen = 0, acc_bytes = 0;
   int len_mem [4096];
   logic [11:0] tx_seq = '0, exp_seq = '0;
   bit stall_mode = 1'b0;
   logic [7:0] fbuf [64];
   int fb_n = 0;
   bit hold_prev = 1'b0;
   logic [7:0] prev_data = '0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] pbyte(input int s, input int j);
      return 8'(s * 29 + j * 7 + 3);
   endfunction

   function automatic logic [31:0] ref_crc(input int n);
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int i = 0; i < n; i++) begin
         for (int b = 7; b >= 0; b--) begin
            logic msb = c[31];
            c = c << 1;
            if (msb ^ fbuf[i][b]) c = c ^ 32'h04C11DB7;
         end
      end
      return ~c;
   endfunction

   task automatic check_frame(input int n);
      logic [11:0] s;
      logic [31:0] got, want;
      bit pay_ok = 1'b1;
      s = {fbuf[0][3:0], fbuf[1]};
      chk(fbuf[0][7:4] == 4'h0, "R1 header high nibble", fbuf[0][7:4], 0);
      chk(s == exp_seq, "R3 frame sequence", s, exp_seq);
      chk(n - 6 == len_mem[s], "R1 payload length", n - 6, len_mem[s]);
      for (int j = 0; j < n - 6; j++) if (fbuf[2 + j] != pbyte(int'(s), j)) pay_ok = 1'b0;
      chk(pay_ok, "R1 payload bytes", pay_ok, 1);
      got  = {fbuf[n-4], fbuf[n-3], fbuf[n-2], fbuf[n-1]};
      want = ref_crc(n - 4);
      chk(got == want, "R2 trailer crc", got, want);
      exp_seq = exp_seq + 1'b1;
      frames_seen++;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 190000) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         out_ready = stall_mode ? ((cyc % 3) != 1) : 1'b1;
         if (hold_prev)
            chk(out_valid && out_data == prev_data, "R4 output held under stall", out_data, prev_data);
         hold_prev = out_valid && !out_ready;
         prev_data = out_data;
         if (out_valid && out_ready) begin
            if (fb_n == 0) chk(out_sop, "R1 sop on first byte", out_sop, 1);
            if (fb_n < 64) fbuf[fb_n] = out_data;
            fb_n++;
            if (out_eop) begin
               check_frame(fb_n);
               fb_n = 0;
            end
         end
      end
   end

   task automatic put(input logic [7:0] b, input bit s, input bit e);
      in_valid = 1'b1; in_data = b; in_sop = s; in_eop = e;
      while (!in_ready) @(negedge clk);
      acc_bytes++;
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
   endtask

   task automatic send_pkt(input int len);
      int s = int'(tx_seq);
      len_mem[s] = len;
      for (int j = 0; j < len; j++) put(pbyte(s, j), j == 0, j == len - 1);
      tx_seq = tx_seq + 1'b1;
   endtask

   task automatic ack(input bit nak, input logic [11:0] s);
      ack_valid = 1'b1; ack_nak = nak; ack_seq = s;
      @(negedge clk);
      ack_valid = 1'b0; ack_nak = 1'b0;
   endtask

   task automatic wait_frames(input int t);
      while (frames_seen < t) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   bit bg_done;
   int base_f, base_b;

   initial begin
      repeat (4) @(negedge clk);
      chk(out_valid == 1'b0, "R9 out_valid in reset", out_valid, 0);
      chk(in_ready == 1'b1, "R9 in_ready in reset", in_ready, 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0, "R9 out_valid after reset", out_valid, 0);
      chk(in_ready == 1'b1, "R9 in_ready after reset", in_ready, 1);

      send_pkt(1); send_pkt(5); send_pkt(16);
      wait_frames(3);
      chk(frames_seen == 3, "R3 three first frames", frames_seen, 3);

      ack(0, 12'd1);
      exp_seq = 12'd2;
      ack(1, 12'd1);
      chk(in_ready == 1'b0, "R7 ready low during resend", in_ready, 0);
      wait_frames(4);
      chk(frames_seen == 4, "R6 resend of packet after N", frames_seen, 4);
      chk(in_ready == 1'b1, "R7 ready back after resend", in_ready, 1);

      ack(1, 12'd2);
      chk(in_ready == 1'b1, "R10 ready stays high", in_ready, 1);
      repeat (30) @(negedge clk);
      chk(frames_seen == 4, "R10 no resend", frames_seen, 4);

      send_pkt(3); send_pkt(9);
      wait_frames(6);
      ack(0, 12'd10);
      ack(0, 12'd2);
      exp_seq = 12'd3;
      ack(1, 12'd2);
      wait_frames(8);
      chk(frames_seen == 8, "R5 ignored acks kept both packets", frames_seen, 8);
      ack(0, 12'd4);

      stall_mode = 1'b1;
      send_pkt(7); send_pkt(16); send_pkt(32);
      wait_frames(11);
      stall_mode = 1'b0;
      ack(0, 12'd7);

      base_f = frames_seen;
      send_pkt(30); send_pkt(30);
      base_b = acc_bytes;
      bg_done = 1'b0;
      fork begin send_pkt(30); bg_done = 1'b1; end join_none
      repeat (40) @(negedge clk);
      chk(in_ready == 1'b0, "R8 ready low with store full", in_ready, 0);
      chk(acc_bytes - base_b == 4, "R8 bytes taken up to store size", acc_bytes - base_b, 4);
      wait_frames(base_f + 1);
      ack(0, 12'd8);
      while (!bg_done) @(negedge clk);
      chk(acc_bytes - base_b == 30, "R8 input resumes after ack", acc_bytes - base_b, 30);
      wait_frames(base_f + 3);
      ack(0, 12'd10);

      base_f = frames_seen;
      for (int i = 0; i < 4; i++) send_pkt(1);
      wait_frames(base_f + 4);
      base_b = acc_bytes;
      bg_done = 1'b0;
      fork begin send_pkt(1); bg_done = 1'b1; end join_none
      repeat (10) @(negedge clk);
      chk(in_ready == 1'b0, "R8 ready low with ring full", in_ready, 0);
      chk(acc_bytes == base_b, "R8 no byte taken with ring full", acc_bytes - base_b, 0);
      ack(0, 12'd11);
      while (!bg_done) @(negedge clk);
      wait_frames(base_f + 5);
      chk(frames_seen == base_f + 5, "R8 ring packet sent after ack", frames_seen, base_f + 5);
      ack(0, 12'd15);

      base_f = frames_seen;
      put(8'hEE, 1'b1, 1'b0);
      put(8'hEE, 1'b0, 1'b0);
      send_pkt(3);
      wait_frames(base_f + 1);
      chk(frames_seen == base_f + 1, "R11 abandoned bytes gave one frame", frames_seen, base_f + 1);
      ack(0, 12'd16);

      while (tx_seq != 12'd4095) begin
         base_f = frames_seen;
         send_pkt(1);
         wait_frames(base_f + 1);
         ack(0, tx_seq - 1'b1);
      end
      base_f = frames_seen;
      send_pkt(2); send_pkt(3); send_pkt(4);
      wait_frames(base_f + 3);
      chk(exp_seq == 12'd2, "R3 sequence wraps to zero", exp_seq, 2);
      exp_seq = 12'd0;
      ack(1, 12'd4095);
      wait_frames(base_f + 5);
      chk(frames_seen == base_f + 5, "R6 resend across wrap", frames_seen, base_f + 5);
      ack(0, 12'd1);
      ack(1, 12'd1);
      chk(in_ready == 1'b1, "R10 no resend after full ack", in_ready, 1);
      repeat (30) @(negedge clk);
      chk(frames_seen == base_f + 5, "R5 wrapped ack freed all", frames_seen, base_f + 5);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule